// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Codes

This block is a purely combinational two's-complement adder/subtractor of parameterized width (32 bits by default). A single control input selects between forming A+B and A-B. Subtraction uses the same adder path. The B operand is inverted bit by bit and the carry-in is forced high, so A + ~B + 1 gives the difference. Unsigned and signed operands use the same path. The only difference between them is how the carry-out is read.

Next to the result, the unit produces four condition flags: zero, negative, carry-out and signed overflow. A comparison decoder is built on the flags. It takes a 4-bit condition select and returns one true/false answer. It covers six signed and four unsigned relations between A and B. A caller sets the subtract control and reads the answer, so no separate magnitude comparator is needed. With the subtract control low, the decoder still evaluates the same formulas on the flags of the addition.

Top module: `addsub_cc`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (A + B) modulo 2^W.
- R2: With `sub_i`=1, `sum_o` equals (A - B) modulo 2^W, formed as A + ~B + 1.
- R3: `carry_o` is the carry out of the top bit position. For subtraction this means it is 1 exactly when A >= B as unsigned numbers.
- R4: `zero_o` is 1 exactly when every bit of `sum_o` is 0.
- R5: `neg_o` equals bit W-1 of `sum_o`.
- R6: `ovf_o` is 1 exactly when the signed result does not fit in W bits. This is the case when both operands entering the adder (B after any inversion) have the same sign and the result's sign differs from it.
- R7: With `sub_i`=1, the signed codes of `cond_sel_i` give the signed relation of A to B: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal.
- R8: With `sub_i`=1, the unsigned codes of `cond_sel_i` give the unsigned relation of A to B: 6 less, 7 less-or-equal, 8 greater, 9 greater-or-equal.
- R9: Codes 10 to 15 of `cond_sel_i` drive `cmp_true_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sub_i | input | 1 | 1 selects A-B, 0 selects A+B |
| cond_sel_i | input | 4 | Comparison code, see R7 to R9 |
| sum_o | output | W | Sum or difference |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the result |
| carry_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow |
| cmp_true_o | output | 1 | Result of the selected comparison |

## Verification
The bench targets the points where the carry chain runs the whole width, such as all ones plus one and 0x80000000 plus itself. A design that breaks the chain early gives a nonzero sum or a lost carry on these inputs. It also covers the signed boundary cases 0x7FFFFFFF+1 and 0x80000000-1. An overflow formula that looks at B before the inversion reports the wrong V for subtraction here, which also flips LT and GE. For each subtraction vector it compares every condition code against signed and unsigned integer comparisons. A carry read as borrow with the wrong polarity inverts every unsigned answer. A swapped code position gives the answer of a neighbouring test. A 5-bit instance repeats the 01011+00101 case to check that the width parameter is honoured.

// File: rtl/addsub_cc_pkg.sv
package addsub_cc_pkg;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_LE  = 4'd3,
    CC_GT  = 4'd4,
    CC_GE  = 4'd5,
    CC_LTU = 4'd6,
    CC_LEU = 4'd7,
    CC_GTU = 4'd8,
    CC_GEU = 4'd9
  } cc_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } ccflags_t;

  // one-bit full adder sum and carry
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  // signed "less than" after A-B
  function automatic logic sgn_less(input ccflags_t f);
    return f.n ^ f.v;
  endfunction

  // unsigned "less than" after A-B: no carry means a borrow occurred
  function automatic logic uns_less(input ccflags_t f);
    return ~f.c;
  endfunction

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         bx_msb_o
);
  import addsub_cc_pkg::*;

  logic [W-1:0] bx;
  logic [W:0]   chain;

  assign bx       = b_i ^ {W{sub_i}};
  assign chain[0] = sub_i;

  generate
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
      assign sum_o[gi]    = fa_sum(a_i[gi], bx[gi], chain[gi]);
      assign chain[gi+1]  = fa_carry(a_i[gi], bx[gi], chain[gi]);
    end
  endgenerate

  assign cout_o   = chain[W];
  assign bx_msb_o = bx[W-1];

  // R2: subtracting an operand from itself always yields zero with carry set
  always_comb begin
    if (sub_i && (a_i == b_i)) begin
      p_self_sub_r2: assert (sum_o == '0 && cout_o);
    end
  end

endmodule

// File: rtl/cc_flags.sv
module cc_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0]              sum_i,
  input  logic                      cout_i,
  input  logic                      a_msb_i,
  input  logic                      bx_msb_i,
  output addsub_cc_pkg::ccflags_t   flags_o
);
  assign flags_o.z = ~|sum_i;
  assign flags_o.n = sum_i[W-1];
  assign flags_o.c = cout_i;
  assign flags_o.v = (a_msb_i == bx_msb_i) && (sum_i[W-1] != a_msb_i);
endmodule

// File: rtl/cc_decode.sv
module cc_decode (
  input  addsub_cc_pkg::ccflags_t flags_i,
  input  logic [3:0]              sel_i,
  output logic                    hit_o
);
  import addsub_cc_pkg::*;

  logic lt_s, lt_u;
  assign lt_s = sgn_less(flags_i);
  assign lt_u = uns_less(flags_i);

  always_comb begin
    unique case (sel_i)
      CC_EQ:   hit_o = flags_i.z;
      CC_NE:   hit_o = ~flags_i.z;
      CC_LT:   hit_o = lt_s;
      CC_LE:   hit_o = lt_s | flags_i.z;
      CC_GT:   hit_o = ~(lt_s | flags_i.z);
      CC_GE:   hit_o = ~lt_s;
      CC_LTU:  hit_o = lt_u;
      CC_LEU:  hit_o = lt_u | flags_i.z;
      CC_GTU:  hit_o = ~lt_u & ~flags_i.z;
      CC_GEU:  hit_o = ~lt_u;
      default: hit_o = 1'b0;
    endcase
  end

  // R9: unused codes never report true
  always_comb begin
    if (sel_i > 4'd9) begin
      p_unused_code_r9: assert (!hit_o);
    end
  end

endmodule

// File: rtl/addsub_cc.sv
module addsub_cc #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [3:0]   cond_sel_i,
  output logic [W-1:0] sum_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         cmp_true_o
);
  import addsub_cc_pkg::*;

  localparam int MSB = W - 1;

  logic     add_cout;
  logic     bx_msb;
  ccflags_t flags;

  addsub_core #(.W(W)) u_core (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (sub_i),
    .sum_o    (sum_o),
    .cout_o   (add_cout),
    .bx_msb_o (bx_msb)
  );

  cc_flags #(.W(W)) u_flags (
    .sum_i    (sum_o),
    .cout_i   (add_cout),
    .a_msb_i  (a_i[MSB]),
    .bx_msb_i (bx_msb),
    .flags_o  (flags)
  );

  cc_decode u_dec (
    .flags_i (flags),
    .sel_i   (cond_sel_i),
    .hit_o   (cmp_true_o)
  );

  assign zero_o  = flags.z;
  assign neg_o   = flags.n;
  assign carry_o = flags.c;
  assign ovf_o   = flags.v;

  always_comb begin
    p_zero_r4: assert (zero_o == (sum_o == '0));
    p_neg_r5:  assert (neg_o == sum_o[MSB]);
    // R6: overflow only with like-signed effective operands
    if (ovf_o) begin
      p_ovf_sign_r6: assert ((a_i[MSB] ^ b_i[MSB]) == sub_i);
    end
    // R7: equality test mirrors the zero flag
    if (cond_sel_i == 4'd0) begin
      p_eq_zero_r7: assert (cmp_true_o == zero_o);
    end
    // R8: unsigned greater-or-equal mirrors the carry
    if (cond_sel_i == 4'd9) begin
      p_geu_carry_r8: assert (cmp_true_o == carry_o);
    end
  end

endmodule

// File: tb/addsub_cc_bench.sv
module addsub_cc_bench;

  localparam int W  = 32;
  localparam int NV = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic         sub;
  logic [3:0]   sel;
  logic         z, n, c, v, hit;

  logic [4:0] a5, b5, s5;
  logic       z5, n5, c5, v5, hit5;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  addsub_cc #(.W(W)) u_addsub_cc (
    .a_i(a), .b_i(b), .sub_i(sub), .cond_sel_i(sel),
    .sum_o(s), .zero_o(z), .neg_o(n), .carry_o(c), .ovf_o(v), .cmp_true_o(hit)
  );

  addsub_cc #(.W(5)) u_addsub_cc_w5 (
    .a_i(a5), .b_i(b5), .sub_i(1'b0), .cond_sel_i(4'd0),
    .sum_o(s5), .zero_o(z5), .neg_o(n5), .carry_o(c5), .ovf_o(v5), .cmp_true_o(hit5)
  );

  // vector: a, b, sub, expected sum, expected {Z,N,C,V}
  localparam logic [W-1:0] VA [NV] = '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd5, 32'd3,
                                       32'h8000_0000, 32'd0, 32'h0000_000B,
                                       32'h8000_0000, 32'h1234_5678};
  localparam logic [W-1:0] VB [NV] = '{32'd1, 32'd1, 32'd3, 32'd5, 32'd1, 32'd0,
                                       32'h0000_0005, 32'h8000_0000, 32'h1234_5678};
  localparam logic VS [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [W-1:0] VSUM [NV] = '{32'd0, 32'h8000_0000, 32'd2, 32'hFFFF_FFFE,
                                         32'h7FFF_FFFF, 32'd0, 32'h0000_0010,
                                         32'd0, 32'd0};
  localparam logic [3:0] VF [NV] = '{4'b1010, 4'b0101, 4'b0010, 4'b0100, 4'b0011,
                                     4'b1010, 4'b0000, 4'b1011, 4'b1010};

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic ts,
                       input logic [3:0] tsel);
    @(negedge clk);
    a = ta; b = tb_; sub = ts; sel = tsel;
    @(posedge clk);
    #2;
  endtask

  // expected comparison result from integer relations
  function automatic logic ref_cmp(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input int code);
    logic signed [W-1:0] xs, ys;
    xs = x; ys = y;
    case (code)
      0: return x == y;
      1: return x != y;
      2: return xs < ys;
      3: return xs <= ys;
      4: return xs > ys;
      5: return xs >= ys;
      6: return x < y;
      7: return x <= y;
      8: return x > y;
      9: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    a = '0; b = '0; sub = 1'b0; sel = 4'd0;
    a5 = 5'b01011; b5 = 5'b00101;

    // idle state: zero operands
    apply('0, '0, 1'b0, 4'd0);
    check("R1 idle sum", s, '0);
    check("R4 idle zero", {31'd0, z}, 32'd1);
    check("R3 idle carry", {31'd0, c}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VA[i], VB[i], VS[i], 4'd0);
      check(VS[i] ? "R2 sum" : "R1 sum", s, VSUM[i]);
      check("R4 zero", {31'd0, z}, {31'd0, VF[i][3]});
      check("R5 neg",  {31'd0, n}, {31'd0, VF[i][2]});
      check("R3 carry", {31'd0, c}, {31'd0, VF[i][1]});
      check("R6 ovf",  {31'd0, v}, {31'd0, VF[i][0]});
      if (VS[i]) begin
        for (int k = 0; k < 16; k++) begin
          apply(VA[i], VB[i], 1'b1, 4'(k));
          check(k < 6 ? "R7 signed cmp" : (k < 10 ? "R8 unsigned cmp" : "R9 unused code"),
                {31'd0, hit}, {31'd0, ref_cmp(VA[i], VB[i], k)});
        end
      end
    end

    // directed: mixed-sign compare where signed and unsigned disagree
    for (int k = 0; k < 10; k++) begin
      apply(32'hFFFF_FFF0, 32'd7, 1'b1, 4'(k));
      check(k < 6 ? "R7 mixed sign" : "R8 mixed sign",
            {31'd0, hit}, {31'd0, ref_cmp(32'hFFFF_FFF0, 32'd7, k)});
    end

    // directed: unused code with all-true flags situation
    apply(32'd9, 32'd9, 1'b1, 4'd15);
    check("R9 code 15", {31'd0, hit}, 32'd0);
    apply(32'd1, 32'd2, 1'b1, 4'd10);
    check("R9 code 10", {31'd0, hit}, 32'd0);

    // directed: 5-bit instance, 01011 + 00101
    #1;
    check("R1 w5 sum",  {27'd0, s5}, 32'h10);
    check("R5 w5 neg",  {31'd0, n5}, 32'd1);
    check("R3 w5 carry", {31'd0, c5}, 32'd0);
    check("R6 w5 ovf",  {31'd0, v5}, 32'd1);

    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule